// File: doc/BRIEF.md
# Asynchronous Serial Channel with Address/Data Marker Bit

This block is a full-duplex asynchronous serial channel for a bus of several nodes. When its multiprocessor format is switched on, every character carries one extra bit between the eight data bits and the stop bit. A 1 in that bit marks the character as an address and a 0 marks it as data. The transmitter takes the outgoing marker from a writable selector bit. The receiver captures the incoming marker into a read-only status bit.

Software or a DMA engine feeds the transmitter through a one-byte holding register. A holding-empty flag and a transmission-finished flag report its state. The finished flag has clear rules of its own. Software clears it with a read-then-write-zero handshake on the empty flag, and any DMA write clears it as well. It is forced high while the transmitter is disabled.

Bit timing comes from an external tick that runs at sixteen times the bit rate. A simple register bus gives access to the control bits, the status bits and both data registers.

Top module: `mpsc_channel`

Register map, selected by `bus_addr`:
- 0 is control: bit 0 enables transmit, bit 1 enables receive, bit 2 enables the marker format.
- 1 is the transmit holding register, write only.
- 2 is status: bit 0 is holding-empty, bit 1 is transmission-finished, bit 2 is the received marker, bit 3 is the transmit marker selector, bit 4 is receive-full.
- 3 is the received byte. Reading it clears receive-full.

## Requirements
- R1: After reset, status reads 8'h03: holding-empty is 1, finished is 1, the received marker is 0 and the selector is 0. Control reads 0, `txd` is high and `dma_req` is low.
- R2: A character on `txd` is a low start bit, then eight data bits LSB first, then the marker bit when the format is on, then a high stop bit. Each bit lasts 16 ticks and the line idles high.
- R3: Holding-empty sets when a byte moves into the shift register. It clears when a byte is written from the bus (address 1) or through `dma_wr`. `dma_req` is high exactly while holding-empty and transmit enable are both 1.
- R4: Finished sets during the stop bit of a character when holding-empty is 1.
- R5: Finished clears when status is written with bit 0 = 0, provided status was read with holding-empty = 1 since the last status write. That write also clears holding-empty. A status write with bit 0 = 0 without such a read changes neither flag.
- R6: A `dma_wr` strobe clears finished while transmit is enabled.
- R7: While transmit enable is 0, finished reads 1 and `txd` is high, even if a character was in flight.
- R8: The selector (status bit 3) gives the marker bit sent. It is sampled when a byte enters the shift register, so a later write affects only the next character. No marker bit is sent when the format is off.
- R9: In marker format, the received marker (status bit 2) takes the marker bit of each received character. Bus writes do not change it.
- R10: While receive enable is 0, the received marker keeps its value and incoming characters are ignored.
- R11: A falling edge on `rxd` that is no longer low 8 ticks later is rejected. No byte is received, and the receiver then accepts the next valid character.
- R12: A received character loads the received-byte register and sets receive-full. Reading address 3 clears receive-full. With the format off, a character has no marker bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dma_req | output | 1 | Transmit holding register wants a byte |
| dma_wr | input | 1 | DMA write strobe into the holding register |
| dma_wdata | input | 8 | DMA write data |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench goes after the finished flag's rules. A write of zero to the empty flag without the preceding read must leave both flags alone; a design that ignored the handshake would drop finished at once. DMA writes that arrive back-to-back must keep finished low until the last character's stop bit, and a design that set the flag per character would pulse it high between characters. The bench changes the marker selector while a character is in flight, which catches a design that reads the selector live instead of at load. It also checks that the received marker holds across receive disable and bus writes, and sends a short low pulse that a receiver without the mid-bit start check would take as a character.

// File: rtl/mpsc_pkg.sv
package mpsc_pkg;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_TXD  = 2'd1,
        ADR_STAT = 2'd2,
        ADR_RXD  = 2'd3
    } reg_adr_e;

    typedef struct packed {
        logic mp_en;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;

    // Index of the last bit in a character (stop bit), counted from the start bit.
    function automatic int unsigned stop_index(input int unsigned data_w, input logic mp_on);
        return mp_on ? data_w + 2 : data_w + 1;
    endfunction

endpackage

// File: rtl/mpsc_tx.sv
module mpsc_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hold_full,
    input  logic              tick,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              mp_on,
    input  logic              mp_sel,
    output logic              load,
    output logic              on_last,
    output logic              txd
);
    import mpsc_pkg::*;

    localparam int FW = DATA_W + 3;
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(FW);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_q;
    logic [FW-1:0] sh_q;
    logic          bit_end;

    assign bit_end = busy_q && tick && (cnt_q == CW'(OVS - 1));
    assign on_last = busy_q && (idx_q == last_q);
    assign load    = en && hold_full && (!busy_q || (bit_end && on_last));
    assign txd     = busy_q ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            last_q <= '0;
            sh_q   <= '1;
        end else if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            idx_q  <= '0;
            last_q <= IW'(stop_index(DATA_W, mp_on));
            sh_q   <= {1'b1, (mp_on ? mp_sel : 1'b1), hold_data, 1'b0};
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
                if (on_last) begin
                    busy_q <= 1'b0;
                end
                idx_q <= idx_q + 1'b1;
                sh_q  <= {1'b1, sh_q[FW-1:1]};
            end
        end
    end
endmodule

// File: rtl/mpsc_rx.sv
module mpsc_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              mp_on,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] byte_out,
    output logic              mp_out,
    output logic              mp_valid
);
    import mpsc_pkg::*;

    localparam int CW  = $clog2(OVS);
    localparam int IW  = $clog2(DATA_W + 2);
    localparam int MID = OVS / 2 - 1;

    rx_state_e         st_q;
    logic [1:0]        sync_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              mp_q;
    logic              rxs;
    logic              at_stop;

    assign rxs     = sync_q[1];
    assign at_stop = (idx_q == IW'(stop_index(DATA_W, mp_on) - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rxd};
        end
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !en) begin
            st_q     <= RX_IDLE;
            cnt_q    <= '0;
            idx_q    <= '0;
            sh_q     <= '0;
            mp_q     <= 1'b0;
            byte_out <= '0;
            mp_out   <= 1'b0;
            mp_valid <= 1'b0;
        end else if (tick) begin
            unique case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (!rxs) st_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == CW'(MID)) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        st_q  <= rxs ? RX_IDLE : RX_SHIFT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_SHIFT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(OVS - 1)) begin
                        idx_q <= idx_q + 1'b1;
                        if (at_stop) begin
                            st_q     <= RX_IDLE;
                            done     <= 1'b1;
                            byte_out <= sh_q;
                            mp_out   <= mp_q;
                            mp_valid <= mp_on;
                        end else if (idx_q < IW'(DATA_W)) begin
                            sh_q <= {rxs, sh_q[DATA_W-1:1]};
                        end else begin
                            mp_q <= rxs;
                        end
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mpsc_channel.sv
module mpsc_channel #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dma_req,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              tick16,
    output logic              txd,
    input  logic              rxd
);
    import mpsc_pkg::*;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              empty_q, fin_q, seen_q, mpsel_q, rfull_q, rmp_q;
    logic              tx_en, rx_en, mp_en;
    logic              wr_ctrl, wr_txd, wr_stat, rd_stat, rd_rxd;
    logic              put_byte, sw_clear;
    logic              tx_load, tx_last;
    logic              rx_done, rx_mp, rx_mp_valid;
    logic [DATA_W-1:0] rx_byte;

    assign tx_en = ctrl_q.tx_en;
    assign rx_en = ctrl_q.rx_en;
    assign mp_en = ctrl_q.mp_en;

    assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_txd   = bus_wr && (bus_addr == ADR_TXD);
    assign wr_stat  = bus_wr && (bus_addr == ADR_STAT);
    assign rd_stat  = bus_rd && (bus_addr == ADR_STAT);
    assign rd_rxd   = bus_rd && (bus_addr == ADR_RXD);
    assign put_byte = wr_txd || dma_wr;
    assign sw_clear = wr_stat && !bus_wdata[0] && seen_q;
    assign dma_req  = empty_q && tx_en;

    mpsc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .en(tx_en), .hold_full(!empty_q), .tick(tick16),
        .hold_data(hold_q), .mp_on(mp_en), .mp_sel(mpsel_q),
        .load(tx_load), .on_last(tx_last), .txd(txd)
    );

    mpsc_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .mp_on(mp_en), .tick(tick16), .rxd(rxd),
        .done(rx_done), .byte_out(rx_byte), .mp_out(rx_mp), .mp_valid(rx_mp_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            hold_q  <= '0;
            empty_q <= 1'b1;
            fin_q   <= 1'b1;
            seen_q  <= 1'b0;
            mpsel_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
            if (wr_txd) hold_q <= bus_wdata;
            else if (dma_wr) hold_q <= dma_wdata;
            if (wr_stat) mpsel_q <= bus_wdata[3];

            if (rd_stat && empty_q) seen_q <= 1'b1;
            else if (wr_stat) seen_q <= 1'b0;

            if (put_byte || sw_clear) empty_q <= 1'b0;
            else if (tx_load) empty_q <= 1'b1;

            if (!tx_en) fin_q <= 1'b1;
            else if (dma_wr || sw_clear) fin_q <= 1'b0;
            else if (tx_last && empty_q) fin_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf_q  <= '0;
            rfull_q <= 1'b0;
            rmp_q   <= 1'b0;
        end else begin
            if (rx_done) begin
                rbuf_q  <= rx_byte;
                rfull_q <= 1'b1;
                if (rx_mp_valid) rmp_q <= rx_mp;
            end else if (rd_rxd) begin
                rfull_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: bus_rdata[2:0] = ctrl_q;
            ADR_TXD:  bus_rdata      = '0;
            ADR_STAT: bus_rdata[4:0] = {rfull_q, mpsel_q, rmp_q, fin_q, empty_q};
            ADR_RXD:  bus_rdata      = rbuf_q;
            default:  bus_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/mpsc_channel_chk.sv
module mpsc_channel_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic rx_en,
    input logic tend,
    input logic empty,
    input logic tx_last,
    input logic txd,
    input logic dma_wr,
    input logic bus_wr,
    input logic rx_mpb
);
    a_r7_fin_forced: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> tend);

    a_r7_line_idle: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> txd);

    a_r6_dma_clears_fin: assert property (@(posedge clk) disable iff (rst)
        (tx_en && dma_wr) |=> !tend);

    a_r4_fin_sets_on_stop: assert property (@(posedge clk) disable iff (rst)
        (tx_en && tx_last && empty && !dma_wr && !bus_wr) |=> tend);

    a_r10_marker_held: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(rx_mpb));
endmodule

bind mpsc_channel mpsc_channel_chk u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tend(fin_q),
    .empty(empty_q), .tx_last(tx_last), .txd(txd), .dma_wr(dma_wr),
    .bus_wr(bus_wr), .rx_mpb(rmp_q)
);

// File: tb/mpsc_channel_bench.sv
`timescale 1ns/1ps
module mpsc_channel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd2;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dma_req;
    logic       dma_wr = 1'b0;
    logic [7:0] dma_wdata = '0;
    logic       tick16 = 1'b0;
    logic       txd;
    logic       rxd = 1'b1;

    int n_chk = 0, n_fail = 0;

    mpsc_channel u_mpsc_channel (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .tick16(tick16), .txd(txd), .rxd(rxd)
    );

    always #2.5 clk = ~clk;
    always @(negedge clk) tick16 = ~tick16;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference of the transmit side ----------------
    bit       m_q[$];
    int       m_sub;
    bit       m_empty, m_fin, m_seen, m_mpsel, m_txen, m_mpen;
    bit [7:0] m_hold;
    bit       r_busy, r_end, r_load, r_last, r_put, r_clr, n_empty, n_fin;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete(); m_sub = 0;
            m_empty = 1; m_fin = 1; m_seen = 0; m_mpsel = 0;
            m_txen = 0; m_mpen = 0; m_hold = 0;
        end else begin
            r_busy = m_q.size() != 0;
            r_last = m_q.size() == 1;
            r_end  = r_busy && tick16 && m_sub == 15;
            r_put  = (bus_wr && bus_addr == 2'd1) || dma_wr;
            r_clr  = bus_wr && bus_addr == 2'd2 && !bus_wdata[0] && m_seen;
            r_load = m_txen && !m_empty && (!r_busy || (r_end && r_last));
            if (!m_txen) n_fin = 1;
            else if (dma_wr || r_clr) n_fin = 0;
            else if (r_last && m_empty) n_fin = 1;
            else n_fin = m_fin;
            if (r_put || r_clr) n_empty = 0;
            else if (r_load) n_empty = 1;
            else n_empty = m_empty;
            if (!m_txen) begin
                m_q.delete(); m_sub = 0;
            end else if (r_load) begin
                m_q.delete(); m_sub = 0;
                m_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
                if (m_mpen) m_q.push_back(m_mpsel);
                m_q.push_back(1'b1);
            end else if (r_busy && tick16) begin
                if (m_sub == 15) begin
                    void'(m_q.pop_front()); m_sub = 0;
                end else m_sub++;
            end
            if (bus_wr && bus_addr == 2'd1) m_hold = bus_wdata;
            else if (dma_wr) m_hold = dma_wdata;
            if (bus_rd && bus_addr == 2'd2 && m_empty) m_seen = 1;
            else if (bus_wr && bus_addr == 2'd2) m_seen = 0;
            if (bus_wr && bus_addr == 2'd2) m_mpsel = bus_wdata[3];
            if (bus_wr && bus_addr == 2'd0) begin
                m_txen = bus_wdata[0]; m_mpen = bus_wdata[2];
            end
            m_empty = n_empty; m_fin = n_fin;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check(txd == (m_q.size() != 0 ? m_q[0] : 1'b1), "R2 R8 txd", txd,
                  m_q.size() != 0 ? m_q[0] : 1);
            check(dma_req == (m_empty && m_txen), "R3 dma_req", dma_req, m_empty && m_txen);
            if (bus_addr == 2'd2)
                check(bus_rdata[1:0] == {m_fin, m_empty}, "R3 R4 fin/empty",
                      bus_rdata[1:0], {m_fin, m_empty});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0; bus_addr = 2'd2;
    endtask

    task automatic br(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0; bus_addr = 2'd2;
    endtask

    task automatic dma(input logic [7:0] d);
        @(negedge clk); dma_wr = 1; dma_wdata = d;
        @(negedge clk); dma_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stat(output logic [7:0] d);
        @(negedge clk); #1 d = bus_rdata;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit mp, input bit use_mp);
        rxd = 0; idle(32);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; idle(32); end
        if (use_mp) begin rxd = mp; idle(32); end
        rxd = 1; idle(64);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] s;
        repeat (4) @(negedge clk);
        rst = 0;
        // R1
        stat(s); check(s == 8'h03, "R1 status", s, 8'h03);
        check(txd == 1 && dma_req == 0, "R1 txd/dma_req", {txd, dma_req}, 2'b10);
        br(2'd0, s); check(s == 8'h00, "R1 ctrl", s, 0);

        // R3, R8: marker format on, selector 1, then changed mid-character
        bw(2'd0, 8'h05);
        stat(s); check(dma_req == 1, "R3 request when empty", dma_req, 1);
        bw(2'd2, 8'h09);
        bw(2'd1, 8'hA5);
        idle(2); stat(s); check(s[0] == 1, "R3 empty after load", s[0], 1);
        idle(40);
        bw(2'd2, 8'h01);
        idle(400);
        stat(s); check(s[3] == 0, "R8 selector written", s[3], 0);

        // R5: handshake clear, then R4 set after the character
        br(2'd2, s);
        bw(2'd2, 8'h00);
        stat(s); check(s[1] == 0, "R5 finished cleared", s[1], 0);
        idle(400);
        stat(s); check(s[1:0] == 2'b11, "R4 finished after stop", s[1:0], 2'b11);
        // R5: write zero without the read
        bw(2'd2, 8'h00);
        stat(s); check(s[1:0] == 2'b11, "R5 no read no clear", s[1:0], 2'b11);

        // R6 and back-to-back DMA, R4 only after the last
        dma(8'h3C);
        stat(s); check(s[1] == 0, "R6 dma clears finished", s[1], 0);
        for (int k = 0; k < 3; k++) begin
            while (!dma_req) @(negedge clk);
            dma(8'h11 * (k + 1));
            stat(s); check(s[1] == 0, "R4 stays low while pending", s[1], 0);
        end
        idle(800);
        stat(s); check(s[1] == 1, "R4 finished after last", s[1], 1);

        // R2, R8: format off, 10-bit characters
        bw(2'd0, 8'h01);
        bw(2'd2, 8'h08);
        dma(8'h81);
        idle(400);
        stat(s); check(s[1:0] == 2'b11, "R2 format off done", s[1:0], 2'b11);

        // R7: disable mid-character
        bw(2'd0, 8'h05);
        dma(8'h55);
        idle(100);
        bw(2'd0, 8'h04);
        stat(s); check(s[1] == 1 && txd == 1, "R7 disabled", {s[1], txd}, 2'b11);

        // R9, R12: receive in marker format
        bw(2'd0, 8'h06);
        send_rx(8'h3C, 1, 1);
        stat(s); check(s[4] == 1 && s[2] == 1, "R9 R12 full+marker", s[4:2], 3'b101);
        br(2'd3, s); check(s == 8'h3C, "R12 data", s, 8'h3C);
        stat(s); check(s[4] == 0, "R12 full cleared", s[4], 0);
        bw(2'd2, 8'h00);
        stat(s); check(s[2] == 1, "R9 read-only marker", s[2], 1);
        send_rx(8'hC3, 0, 1);
        stat(s); check(s[2] == 0, "R9 marker zero", s[2], 0);
        br(2'd3, s); check(s == 8'hC3, "R12 data 2", s, 8'hC3);
        send_rx(8'h5A, 1, 1);
        br(2'd3, s);
        // R10
        bw(2'd0, 8'h04);
        stat(s); check(s[2] == 1, "R10 marker held on disable", s[2], 1);
        send_rx(8'h77, 0, 1);
        stat(s); check(s[2] == 1 && s[4] == 0, "R10 ignored while off", s[4:2], 3'b001);

        // R11: glitch, then a good character
        bw(2'd0, 8'h06);
        idle(8);
        rxd = 0; idle(8); rxd = 1; idle(100);
        stat(s); check(s[4] == 0, "R11 glitch rejected", s[4], 0);
        send_rx(8'h96, 0, 1);
        br(2'd3, s); check(s == 8'h96, "R11 recovers", s, 8'h96);

        // R12 with format off: no marker bit, marker unchanged
        bw(2'd0, 8'h02);
        send_rx(8'h11, 1, 0);
        stat(s); check(s[4] == 1 && s[2] == 0, "R12 R9 format off", s[4:2], 3'b100);
        br(2'd3, s); check(s == 8'h11, "R12 data format off", s, 8'h11);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule